// File: doc/BRIEF.md
# Pipelined SPI Register Read Slave

This block lets an SPI master read a bank of 16-bit registers. Traffic is cut into 16-clock frames, each opened by pulling the active-low chip select low. A frame whose upper byte holds a register address and whose lower byte is zero is a read command. The slave answers it one frame later, so while a command is arriving the slave shifts out the answer to the command before it. A master can therefore issue reads back to back and close the chain with an all-zero frame.

The SPI pins are brought into the system clock domain by a two-stage synchronizer and sampled there, so SCLK must run well below the system clock. The interface uses SPI mode 3: MOSI is sampled on the rising SCLK edge and MISO changes on the falling edge. On the register side the slave holds the pending byte address on `reg_addr`. At the start of the response frame it gives a one-cycle `reg_rd_strobe` and copies `reg_rdata` into its output shifter.

A frame state machine in `spr_frame_fsm` has three states. FS_IDLE means select is high. FS_RECV means bits are arriving. FS_FULL means 16 bits are in and any further clocks are ignored. It has four transitions. IDLE goes to RECV when select falls, which also loads the output shifter. RECV goes to FULL on the 16th rising edge. RECV goes back to IDLE when select rises early, which discards the frame. FULL goes to IDLE when select rises, which commits the frame to the decoder.

Top module: `spr_read_slave`

## Requirements
- R1: After reset `spi_miso` and `reg_rd_strobe` are 0, and the first complete frame shifts out 0x0000.
- R2: A frame is the first 16 rising SCLK edges while `spi_cs_n` is low. MOSI bits are taken MSB first and form a 16-bit word.
- R3: A word with a nonzero upper byte and a lower byte of 0x00 is a read command. Once select rises, its upper byte appears on `reg_addr` and stays there until the next complete frame.
- R4: The 16 bits shifted out while a command arrives are the response to the earlier command, not the data of the register being addressed.
- R5: In the frame after a read command, `spi_miso` carries the register's 16-bit value MSB first. Bit 15 is valid before the first rising edge, and each later bit changes on a falling edge.
- R6: At the start of each response frame, `reg_rd_strobe` pulses exactly once for one system clock. The value latched then is the one shifted out for the whole frame.
- R7: A complete 0x0000 frame returns the pending response and clears it, so the next frame returns 0x0000.
- R8: A read command in the response frame returns the earlier register and queues the new address, giving back-to-back reads.
- R9: If select rises before 16 bits have arrived, the frame is dropped and the pending read is kept.
- R10: A complete frame with a nonzero lower byte acts like a 0x0000 frame: it queues nothing and clears the pending read.
- R11: `spi_miso` is 0 while `spi_cs_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | SPI clock from the master, idle high |
| spi_cs_n | input | 1 | Active-low frame select |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master, 0 while not selected |
| reg_addr | output | 8 | Byte address of the pending read |
| reg_rd_strobe | output | 1 | One-cycle pulse when the register value is latched |
| reg_rdata | input | 16 | Register value for `reg_addr` |

## Verification
The register model returns a value built from the address whose two bytes differ, so a swapped byte order or a response from the wrong address shows up. Single reads show the one-frame delay and the 0x0000 answer after a no-op. Chains of back-to-back commands show the new address being queued while the old data is returned. Truncated frames, a command with a nonzero lower byte and the top address 0xFF separate a dropped frame, a cancelled read and the edges of decoding, and strobe counting shows whether the register was read exactly once.

// File: rtl/spr_pkg.sv
package spr_pkg;

    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_RECV = 2'd1,
        FS_FULL = 2'd2
    } frame_state_t;

endpackage

// File: rtl/spr_sync.sv
module spr_sync #(
    parameter int            WIDTH   = 3,
    parameter int            STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain <= {STAGES{RST_VAL[b]}};
            end else begin
                chain <= {chain[STAGES-2:0], async_in[b]};
            end
        end

        assign sync_out[b] = chain[STAGES-1];
    end

endmodule

// File: rtl/spr_frame_fsm.sv
module spr_frame_fsm
    import spr_pkg::*;
#(
    parameter int FRAME_BITS = 16,
    localparam int CNT_W     = $clog2(FRAME_BITS + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sclk_s,
    input  logic                  cs_n_s,
    input  logic                  mosi_s,
    output logic                  frame_start,
    output logic                  frame_commit,
    output logic                  shift_en,
    output logic                  active,
    output logic [FRAME_BITS-1:0] rx_word
);

    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_BITS - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FRAME_BITS);

    frame_state_t          state, state_nx;
    logic                  sclk_q, cs_q;
    logic [CNT_W-1:0]      bit_cnt;
    logic [FRAME_BITS-1:0] rx_sr;
    logic                  sclk_rise, sclk_fall, cs_fall, cs_rise;

    assign sclk_rise = sclk_s & ~sclk_q;
    assign sclk_fall = ~sclk_s & sclk_q;
    assign cs_fall   = cs_q & ~cs_n_s;
    assign cs_rise   = ~cs_q & cs_n_s;

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            FS_IDLE: if (cs_fall) state_nx = FS_RECV;
            FS_RECV: begin
                if (cs_rise)                               state_nx = FS_IDLE;
                else if (sclk_rise && bit_cnt == LAST_BIT) state_nx = FS_FULL;
            end
            FS_FULL: if (cs_rise) state_nx = FS_IDLE;
            default: state_nx = FS_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= FS_IDLE;
        else        state <= state_nx;
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q       <= 1'b1;
            cs_q         <= 1'b1;
            bit_cnt      <= '0;
            rx_sr        <= '0;
            frame_start  <= 1'b0;
            frame_commit <= 1'b0;
            shift_en     <= 1'b0;
        end else begin
            sclk_q       <= sclk_s;
            cs_q         <= cs_n_s;
            frame_start  <= (state == FS_IDLE) && cs_fall;
            frame_commit <= (state == FS_FULL) && cs_rise;
            shift_en     <= (state == FS_RECV) && sclk_fall && (bit_cnt != '0);
            unique case (state)
                FS_IDLE: bit_cnt <= '0;
                FS_RECV: begin
                    if (sclk_rise) begin
                        bit_cnt <= bit_cnt + 1'b1;
                        rx_sr   <= {rx_sr[FRAME_BITS-2:0], mosi_s};
                    end
                end
                FS_FULL: ;
                default: bit_cnt <= '0;
            endcase
        end
    end

    assign active  = (state != FS_IDLE);
    assign rx_word = rx_sr;

    // R2
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= FULL_CNT);

    // R9
    commit_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_commit |-> bit_cnt == FULL_CNT);

endmodule

// File: rtl/spr_tx_shift.sv
module spr_tx_shift #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_val,
    input  logic              shift_en,
    input  logic              active,
    output logic              miso
);

    logic [DATA_W-1:0] tx_sr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        tx_sr <= '0;
        else if (load)     tx_sr <= load_val;
        else if (shift_en) tx_sr <= {tx_sr[DATA_W-2:0], 1'b0};
    end

    assign miso = active ? tx_sr[DATA_W-1] : 1'b0;

    // R6
    load_shift_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && shift_en));

    // R11
    shift_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |-> active);

endmodule

// File: rtl/spr_read_slave.sv
module spr_read_slave
    import spr_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sclk,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              reg_rd_strobe,
    input  logic [DATA_W-1:0] reg_rdata
);

    localparam int FRAME_BITS = DATA_W;
    localparam int LOW_W      = FRAME_BITS - ADDR_W;

    logic [2:0]            pins_s;
    logic                  frame_start, frame_commit, shift_en, active;
    logic [FRAME_BITS-1:0] rx_word;
    logic                  pend_valid;
    logic [ADDR_W-1:0]     pend_addr;
    logic                  is_read_cmd;
    logic [DATA_W-1:0]     load_val;

    spr_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b011)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({spi_mosi, spi_cs_n, spi_sclk}),
        .sync_out (pins_s)
    );

    spr_frame_fsm #(.FRAME_BITS(FRAME_BITS)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .sclk_s       (pins_s[0]),
        .cs_n_s       (pins_s[1]),
        .mosi_s       (pins_s[2]),
        .frame_start  (frame_start),
        .frame_commit (frame_commit),
        .shift_en     (shift_en),
        .active       (active),
        .rx_word      (rx_word)
    );

    assign is_read_cmd = (rx_word[LOW_W-1:0] == '0) &&
                         (rx_word[FRAME_BITS-1:LOW_W] != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_valid <= 1'b0;
            pend_addr  <= '0;
        end else if (frame_commit) begin
            pend_valid <= is_read_cmd;
            if (is_read_cmd) pend_addr <= rx_word[FRAME_BITS-1:LOW_W];
        end
    end

    assign reg_addr      = pend_addr;
    assign reg_rd_strobe = frame_start && pend_valid;
    assign load_val      = pend_valid ? reg_rdata : '0;

    spr_tx_shift #(.DATA_W(DATA_W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (frame_start),
        .load_val (load_val),
        .shift_en (shift_en),
        .active   (active),
        .miso     (spi_miso)
    );

    // R6
    strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_strobe |=> !reg_rd_strobe);

    // R9
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_commit |=> $stable(pend_addr) && $stable(pend_valid));

    // R3
    addr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_valid |-> pend_addr != '0);

endmodule

// File: tb/tb_spr_read_slave.sv
`timescale 1ns/1ps
module tb_spr_read_slave;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        spi_sclk = 1'b1;
    logic        spi_cs_n = 1'b1;
    logic        spi_mosi = 1'b0;
    logic        spi_miso;
    logic [7:0]  reg_addr;
    logic        reg_rd_strobe;
    logic [15:0] reg_rdata;
    int          checks = 0;
    int          errors = 0;
    int          strobes = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    function automatic logic [15:0] model(input logic [7:0] a);
        return {a ^ 8'hA5, a + 8'h3C};
    endfunction

    assign reg_rdata = model(reg_addr);

    always @(posedge clk) if (reg_rd_strobe) strobes++;

    spr_read_slave dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .spi_sclk      (spi_sclk),
        .spi_cs_n      (spi_cs_n),
        .spi_mosi      (spi_mosi),
        .spi_miso      (spi_miso),
        .reg_addr      (reg_addr),
        .reg_rd_strobe (reg_rd_strobe),
        .reg_rdata     (reg_rdata)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic frame(input logic [15:0] word, input int nbits, output logic [15:0] got);
        got = '0;
        spi_cs_n = 1'b0;
        #80;
        for (int i = 0; i < nbits; i++) begin
            spi_sclk = 1'b0;
            spi_mosi = word[15-i];
            #40;
            got[15-i] = spi_miso;
            spi_sclk = 1'b1;
            #40;
        end
        #80;
        spi_cs_n = 1'b1;
        spi_mosi = 1'b0;
        #200;
    endtask

    task automatic t_reset();
        logic [15:0] g;
        chk("R1 miso after reset", {15'd0, spi_miso}, 16'd0);
        chk("R1 strobe after reset", {15'd0, reg_rd_strobe}, 16'd0);
        frame(16'h0400, 16, g);
        chk("R1 R4 first frame data", g, 16'h0000);
        chk("R3 reg_addr after cmd", {8'd0, reg_addr}, 16'h0004);
    endtask

    task automatic t_single_read();
        logic [15:0] g;
        int s0;
        s0 = strobes;
        frame(16'h0000, 16, g);
        chk("R5 single read data", g, model(8'h04));
        chk("R6 one strobe per response", 16'(strobes - s0), 16'd1);
        frame(16'h0000, 16, g);
        chk("R7 after no-op", g, 16'h0000);
        chk("R6 no strobe without pending", 16'(strobes - s0), 16'd1);
    endtask

    task automatic t_back_to_back();
        logic [15:0] g;
        frame(16'h1200, 16, g);
        chk("R4 cmd frame after no-op", g, 16'h0000);
        chk("R2 R3 addr decode", {8'd0, reg_addr}, 16'h0012);
        frame(16'h3400, 16, g);
        chk("R8 b2b first data", g, model(8'h12));
        chk("R8 b2b new addr", {8'd0, reg_addr}, 16'h0034);
        frame(16'h0000, 16, g);
        chk("R8 b2b second data", g, model(8'h34));
        chk("R11 miso idle", {15'd0, spi_miso}, 16'd0);
    endtask

    task automatic t_partial();
        logic [15:0] g;
        frame(16'h5600, 16, g);
        chk("R4 cmd frame 56", g, 16'h0000);
        frame(16'h7800, 8, g);
        chk("R9 addr kept after partial", {8'd0, reg_addr}, 16'h0056);
        frame(16'h0000, 16, g);
        chk("R9 pending kept", g, model(8'h56));
    endtask

    task automatic t_malformed();
        logic [15:0] g;
        frame(16'h2200, 16, g);
        frame(16'h9A01, 16, g);
        chk("R10 prior data returned", g, model(8'h22));
        frame(16'h0000, 16, g);
        chk("R10 nonzero low byte no read", g, 16'h0000);
    endtask

    task automatic t_top_addr();
        logic [15:0] g;
        frame(16'hFF00, 16, g);
        frame(16'h0000, 16, g);
        chk("R5 addr FF data", g, model(8'hFF));
        chk("R11 miso low after frame", {15'd0, spi_miso}, 16'd0);
    endtask

    initial begin
        #(2_000_000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #51;
        rst_n = 1'b1;
        #100;
        t_reset();
        t_single_read();
        t_back_to_back();
        t_partial();
        t_malformed();
        t_top_addr();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule